// File: doc/BRIEF.md
# Block Transfer Micro-op Sequencer

This block expands one decoded multi-register memory transfer instruction into an ordered series of micro-operations. It emits one per accepted handshake on its output. The instruction supplies a base register number, a pre-index flag, an up flag, a user flag, a writeback flag, a load flag and a register list with one bit per architectural register. The sequencer first copies the base into a scratch register. It then issues one load or store per listed register, with an offset relative to that scratch copy, and updates the base when writeback is requested. Load sequences update the base near the start and store sequences update it at the end.

Each micro-op carries an operation code, a register number, a user-bank flag, an unsigned byte offset and a last flag. The downstream pipeline uses the user-bank flag to redirect a transfer to the user-mode register bank. It uses the exception-return operation code to treat the top register's load as a return from an exception. A new instruction is taken only when the previous sequence has fully drained.

Top module: `lsm_uop_seq`

## Requirements
- R1: An instruction with N set list bits produces exactly N + 1 micro-ops, plus one more when writeback is set. out_valid then falls and in_ready rises.
- R2: The first micro-op is a base copy: op code 0, out_reg equal to the base register, offset 0.
- R3: With writeback on a load, the writeback op is the second micro-op. With writeback on a store, it is the final micro-op, after every transfer.
- R4: The writeback op is add-immediate (op code 1) when up is set and subtract-immediate (op code 2) when up is clear. Its out_reg is the base register and its offset is 4·N.
- R5: Transfers visit the listed registers in ascending index order, one op per set bit. They use op code 3 for loads and op code 5 for stores, with out_reg the transferred register.
- R6: The first transfer offset is 0 when up is set and 4·N − 4 when up is clear, plus 4 when the pre-index flag is clear. Each later transfer moves by 4, up when up is set and down otherwise.
- R7: When the user flag is set and the top list bit (index REG_CNT−1) is clear, every transfer has out_usr_bank = 1. In every other case, and on all non-transfer ops, out_usr_bank is 0.
- R8: When the user flag is set, the top list bit is set and the op is a load, the transfer of the top register uses op code 4 (exception-return load). Other registers and stores are unaffected.
- R9: out_last is 1 on the final micro-op of a sequence and 0 on every other one.
- R10: An empty register list yields the base copy alone, or the base copy then the writeback op when writeback is set, with out_last on the final one.
- R11: in_ready is 1 only while no sequence is in progress. An instruction presented while busy is ignored and leaves the running sequence unchanged.
- R12: While out_valid is 1 and out_ready is 0, all output fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken this cycle if offered |
| in_base | input | IDX_W | Base register number |
| in_pre | input | 1 | Pre-index (offset applied before transfer) |
| in_up | input | 1 | Ascending addresses when set |
| in_user | input | 1 | User-bank / exception-return qualifier |
| in_wb | input | 1 | Update base register |
| in_load | input | 1 | Load when set, store when clear |
| in_list | input | REG_CNT | Register list, bit i selects register i |
| out_valid | output | 1 | Micro-op available |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_op | output | 3 | Operation code (0 copy, 1 add-imm, 2 sub-imm, 3 load, 4 exception-return load, 5 store) |
| out_reg | output | IDX_W | Register operated on |
| out_usr_bank | output | 1 | Transfer uses the user-mode bank |
| out_off | output | OFF_W | Unsigned byte offset or immediate |
| out_last | output | 1 | Final micro-op of the sequence |

## Verification
Two things can land in the same cycle. The final transfer of a list is one op, and the decision whether it is also the end of the sequence, or whether a trailing writeback follows, must be made in that op's cycle. The bench sweeps every register list of a reduced 8-register configuration across all flag combinations. It therefore reaches the final transfer with the load/store and writeback flags in every pairing, and compares out_last and the following op against an arithmetic model. The second collision is a stalled output meeting a fresh instruction offered at the input. On alternate instructions the bench keeps presenting random instructions throughout the busy period while out_ready is randomly withheld. It checks that in_ready stays low, that the stalled fields do not move, and that the running sequence completes exactly as modelled.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [2:0] {
      UOP_COPY  = 3'd0,
      UOP_ADDI  = 3'd1,
      UOP_SUBI  = 3'd2,
      UOP_LOAD  = 3'd3,
      UOP_LDRET = 3'd4,
      UOP_STORE = 3'd5
   } uop_e;

   typedef enum logic [1:0] {
      PH_COPY     = 2'd0,
      PH_WB_EARLY = 2'd1,
      PH_XFER     = 2'd2,
      PH_WB_LATE  = 2'd3
   } phase_e;

endpackage

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
   parameter int W  = 16,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   if (W < 1) begin : g_bad_w
      $error("lsm_popcnt: W must be at least 1");
   end

   always_comb begin
      cnt = '0;
      for (int i = 0; i < W; i++) begin
         cnt = cnt + CW'(vec[i]);
      end
   end

endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   if (W < 2) begin : g_bad_w
      $error("lsm_lowbit: W must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

   // R5: the chosen index is set and nothing below it is set
   always_comb begin
      if (any) begin
         p_lowest_set_r5: assert (vec[idx] &&
            ((vec & ((W'(1) << idx) - W'(1))) == '0));
      end
   end

endmodule

// File: rtl/lsm_start_off.sv
module lsm_start_off #(
   parameter int CW    = 5,
   parameter int OFF_W = 7,
   parameter int STEP  = 4
) (
   input  logic [CW-1:0]    cnt,
   input  logic             up,
   input  logic             pre,
   output logic [OFF_W-1:0] off
);

   localparam logic [OFF_W-1:0] STEP_W = OFF_W'(STEP);

   always_comb begin
      if (up) off = '0;
      else    off = STEP_W * OFF_W'(cnt) - STEP_W;
      if (!pre) off = off + STEP_W;
   end

endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
   import lsm_pkg::*;
#(
   parameter int REG_CNT = 16,
   parameter int STEP    = 4,
   localparam int IDX_W  = $clog2(REG_CNT),
   localparam int CNT_W  = $clog2(REG_CNT + 1),
   localparam int OFF_W  = $clog2(STEP * REG_CNT + STEP + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [IDX_W-1:0]   in_base,
   input  logic               in_pre,
   input  logic               in_up,
   input  logic               in_user,
   input  logic               in_wb,
   input  logic               in_load,
   input  logic [REG_CNT-1:0] in_list,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [2:0]         out_op,
   output logic [IDX_W-1:0]   out_reg,
   output logic               out_usr_bank,
   output logic [OFF_W-1:0]   out_off,
   output logic               out_last
);

   localparam int               RET_IDX = REG_CNT - 1;
   localparam logic [OFF_W-1:0] STEP_W  = OFF_W'(STEP);

   if (REG_CNT < 2) begin : g_bad_cnt
      $error("lsm_uop_seq: REG_CNT must be at least 2");
   end
   if (STEP < 1) begin : g_bad_step
      $error("lsm_uop_seq: STEP must be positive");
   end

   // ---------------- state ----------------
   logic               busy_q;
   phase_e             phase_q;
   logic [IDX_W-1:0]   base_q;
   logic               up_q, wb_q, load_q, fusr_q, eret_q;
   logic [REG_CNT-1:0] list_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [OFF_W-1:0]   off_q;

   // ---------------- input-side decode ----------------
   logic [CNT_W-1:0] in_cnt;
   logic [OFF_W-1:0] in_start;

   lsm_popcnt #(.W(REG_CNT), .CW(CNT_W)) u_cnt (
      .vec (in_list),
      .cnt (in_cnt)
   );

   lsm_start_off #(.CW(CNT_W), .OFF_W(OFF_W), .STEP(STEP)) u_start (
      .cnt (in_cnt),
      .up  (in_up),
      .pre (in_pre),
      .off (in_start)
   );

   // ---------------- remaining-list scan ----------------
   logic             lst_any;
   logic [IDX_W-1:0] lst_idx;
   logic [REG_CNT-1:0] lst_rest;

   lsm_lowbit #(.W(REG_CNT), .IW(IDX_W)) u_low (
      .vec (list_q),
      .any (lst_any),
      .idx (lst_idx)
   );

   assign lst_rest = list_q & ~(REG_CNT'(1) << lst_idx);

   // ---------------- current op and successor ----------------
   uop_e             op_c;
   logic [IDX_W-1:0] reg_c;
   logic             usr_c;
   logic [OFF_W-1:0] off_c;
   phase_e           nxt_c;
   logic             done_c;
   logic [OFF_W-1:0] wb_imm;
   uop_e             wb_op;
   uop_e             xfer_op;

   assign wb_imm = STEP_W * OFF_W'(cnt_q);
   assign wb_op  = up_q ? UOP_ADDI : UOP_SUBI;

   always_comb begin
      if (!load_q)                                   xfer_op = UOP_STORE;
      else if (eret_q && lst_idx == IDX_W'(RET_IDX)) xfer_op = UOP_LDRET;
      else                                           xfer_op = UOP_LOAD;
   end

   always_comb begin
      op_c   = UOP_COPY;
      reg_c  = base_q;
      usr_c  = 1'b0;
      off_c  = '0;
      nxt_c  = PH_COPY;
      done_c = 1'b1;
      unique case (phase_q)
         PH_COPY: begin
            if (load_q && wb_q) begin
               nxt_c = PH_WB_EARLY; done_c = 1'b0;
            end else if (lst_any) begin
               nxt_c = PH_XFER;     done_c = 1'b0;
            end else if (wb_q) begin
               nxt_c = PH_WB_LATE;  done_c = 1'b0;
            end
         end
         PH_WB_EARLY: begin
            op_c  = wb_op;
            off_c = wb_imm;
            if (lst_any) begin
               nxt_c = PH_XFER; done_c = 1'b0;
            end
         end
         PH_XFER: begin
            op_c  = xfer_op;
            reg_c = lst_idx;
            usr_c = fusr_q;
            off_c = off_q;
            if (|lst_rest) begin
               nxt_c = PH_XFER;    done_c = 1'b0;
            end else if (wb_q && !load_q) begin
               nxt_c = PH_WB_LATE; done_c = 1'b0;
            end
         end
         PH_WB_LATE: begin
            op_c  = wb_op;
            off_c = wb_imm;
         end
         default: ;
      endcase
   end

   // ---------------- sequencing ----------------
   logic take, fire;
   assign take = in_valid && !busy_q;
   assign fire = busy_q && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= PH_COPY;
         base_q  <= '0;
         up_q    <= 1'b0;
         wb_q    <= 1'b0;
         load_q  <= 1'b0;
         fusr_q  <= 1'b0;
         eret_q  <= 1'b0;
         list_q  <= '0;
         cnt_q   <= '0;
         off_q   <= '0;
      end else if (take) begin
         busy_q  <= 1'b1;
         phase_q <= PH_COPY;
         base_q  <= in_base;
         up_q    <= in_up;
         wb_q    <= in_wb;
         load_q  <= in_load;
         fusr_q  <= in_user && !in_list[RET_IDX];
         eret_q  <= in_user &&  in_list[RET_IDX];
         list_q  <= in_list;
         cnt_q   <= in_cnt;
         off_q   <= in_start;
      end else if (fire) begin
         if (done_c) busy_q <= 1'b0;
         phase_q <= nxt_c;
         if (phase_q == PH_XFER) begin
            list_q <= lst_rest;
            off_q  <= up_q ? off_q + STEP_W : off_q - STEP_W;
         end
      end
   end

   assign in_ready     = !busy_q;
   assign out_valid    = busy_q;
   assign out_op       = op_c;
   assign out_reg      = reg_c;
   assign out_usr_bank = usr_c;
   assign out_off      = off_c;
   assign out_last     = done_c;

   // ---------------- assertions ----------------
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_op) &&
      $stable(out_reg) && $stable(out_off) && $stable(out_usr_bank) &&
      $stable(out_last));

   p_first_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && out_op == 3'(UOP_COPY) &&
      out_reg == $past(in_base) && out_off == '0);

   p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid && in_ready);

   p_ret_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_op == 3'(UOP_LDRET) |-> out_reg == IDX_W'(RET_IDX));

   p_bank_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_usr_bank |-> out_op == 3'(UOP_LOAD) ||
      out_op == 3'(UOP_STORE));

   p_no_take_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_ready && out_last) |=> out_valid && !in_ready);

endmodule

// File: tb/lsm_uop_seq_bench.sv
`timescale 1ns/1ps
module lsm_uop_seq_bench;

   localparam int NREG  = 8;
   localparam int IDX_W = $clog2(NREG);
   localparam int OFF_W = $clog2(4 * NREG + 4 + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [IDX_W-1:0] in_base = '0;
   logic             in_pre = 1'b0, in_up = 1'b0, in_user = 1'b0;
   logic             in_wb = 1'b0, in_load = 1'b0;
   logic [NREG-1:0]  in_list = '0;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [2:0]       out_op;
   logic [IDX_W-1:0] out_reg;
   logic             out_usr_bank;
   logic [OFF_W-1:0] out_off;
   logic             out_last;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   lsm_uop_seq #(.REG_CNT(NREG), .STEP(4)) u_lsm_uop_seq (
      .clk, .rst_n, .in_valid, .in_ready, .in_base, .in_pre, .in_up,
      .in_user, .in_wb, .in_load, .in_list, .out_valid, .out_ready,
      .out_op, .out_reg, .out_usr_bank, .out_off, .out_last
   );

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000) begin
         failures++;
         $display("FAIL watchdog: run did not finish (actual cycles=%0d expected < 190000)", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // expected sequence
   int e_op[16], e_reg[16], e_usr[16], e_off[16];
   string e_tag[16];
   int e_n;

   task automatic build(input int base, input bit pre, input bit up, input bit usr,
                        input bit wb, input bit ld, input logic [NREG-1:0] lst);
      int n, off, wbop;
      bit fu, er;
      n = 0;
      for (int i = 0; i < NREG; i++) n += lst[i];
      fu = usr && !lst[NREG-1];
      er = usr && lst[NREG-1];
      wbop = up ? 1 : 2;
      e_n = 0;
      e_op[e_n] = 0; e_reg[e_n] = base; e_usr[e_n] = 0; e_off[e_n] = 0;
      e_tag[e_n] = (n == 0) ? "R2 R10" : "R2"; e_n++;
      if (ld && wb) begin
         e_op[e_n] = wbop; e_reg[e_n] = base; e_usr[e_n] = 0; e_off[e_n] = 4 * n;
         e_tag[e_n] = "R3 R4"; e_n++;
      end
      off = up ? 0 : 4 * n - 4;
      if (!pre) off += 4;
      for (int r = 0; r < NREG; r++) begin
         if (lst[r]) begin
            e_op[e_n] = !ld ? 5 : ((er && r == NREG - 1) ? 4 : 3);
            e_reg[e_n] = r; e_usr[e_n] = fu; e_off[e_n] = off;
            e_tag[e_n] = (e_op[e_n] == 4) ? "R8 R5" : "R5 R6 R7";
            e_n++;
            off = up ? off + 4 : off - 4;
         end
      end
      if (!ld && wb) begin
         e_op[e_n] = wbop; e_reg[e_n] = base; e_usr[e_n] = 0; e_off[e_n] = 4 * n;
         e_tag[e_n] = "R3 R4"; e_n++;
      end
   endtask

   task automatic run_one(input int code);
      logic [NREG-1:0] lst;
      int base, k;
      bit junk, stalled;
      lst  = code[7:0];
      base = (code ^ (code >> 5)) & (NREG - 1);
      junk = code[0] ^ code[9];
      build(base, code[8], code[9], code[10], code[11], code[12], lst);
      @(negedge clk);
      chk(in_ready == 1'b1, "R11 idle ready", int'(in_ready), 1);
      in_valid = 1'b1; in_base = IDX_W'(base); in_list = lst;
      in_pre = code[8]; in_up = code[9]; in_user = code[10];
      in_wb = code[11]; in_load = code[12];
      k = 0;
      stalled = 1'b0;
      while (k < e_n) begin
         @(negedge clk);
         step_lfsr();
         if (junk) begin
            in_valid = 1'b1; in_list = lfsr[7:0]; in_base = lfsr[10:8];
            in_up = lfsr[11]; in_wb = lfsr[12]; in_load = lfsr[13];
            in_user = lfsr[14]; in_pre = lfsr[15];
            chk(in_ready == 1'b0, "R11 busy not ready", int'(in_ready), 0);
         end else begin
            in_valid = 1'b0;
         end
         chk(out_valid == 1'b1, "R1 valid in sequence", int'(out_valid), 1);
         chk(int'(out_op) == e_op[k] && int'(out_reg) == e_reg[k],
             stalled ? {e_tag[k], " R12 op/reg"} : {e_tag[k], " op/reg"},
             int'(out_op) * 100 + int'(out_reg), e_op[k] * 100 + e_reg[k]);
         chk(int'(out_off) == e_off[k], {e_tag[k], " offset"}, int'(out_off), e_off[k]);
         chk(int'(out_usr_bank) == e_usr[k], "R7 user bank", int'(out_usr_bank), e_usr[k]);
         chk(out_last == (k == e_n - 1), "R9 last flag", int'(out_last), int'(k == e_n - 1));
         out_ready = lfsr[0] | lfsr[1];
         stalled = !out_ready;
         if (out_ready) k++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      out_ready = 1'b0;
      chk(out_valid == 1'b0, (lst == 0) ? "R10 R1 length" : "R1 length", int'(out_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R11 ready after reset", int'(in_ready), 1);
      for (int code = 0; code < 8192; code++) run_one(code);
      summary();
      $finish;
   end

endmodule